// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement Unit

This block holds the replacement history for a four-way set-associative cache with a configurable number of sets. Each set has a three-node binary tree. The four ways are the leaves of the tree. Whenever the cache reports an access, as a set index plus the way that was used, the nodes on the path to that way are turned to point at it. The block does not store tags or data, and it does not decide hits. It only keeps this ordering and names a way to replace.

When a fill needs room, the cache presents a query set index. The block answers combinationally with a victim way. It finds that way by walking down the tree and taking, at every node, the branch opposite to the one the node marks as recently used. State changes only at the clock edge. A query and an access to the same set in the same cycle therefore see the history from before that access.

Top module: `plru4_repl_unit`

## Requirements
- R1: A synchronous active-low reset clears every tree node of every set. The victim for every set is then way 3.
- R2: One cycle after an access to way w of set s, the victim reported for set s lies in the other half of the set. Ways 0 and 1 form one half, and ways 2 and 3 form the other.
- R3: One cycle after an access to way w of set s, the victim reported for set s is never w.
- R4: The victim is encoded as a 2-bit way number and is found by a fixed walk. The top node records which half was used last (0 for ways 0/1, 1 for ways 2/3). The walk enters the other half. In ways 0/1, the node holds the index of the way used last. In ways 2/3, the node holds 0 when way 2 was used last and 1 when way 3 was used last. The walk takes the way not recorded.
- R5: A cycle with the access valid input low leaves all history unchanged, whatever set and way are presented.
- R6: An access updates only the set it names. The victims of all other sets stay as they were.
- R7: When an access and a query name the same set in the same cycle, the victim reflects the history before that access.
- R8: Starting from reset, the accesses 3, 0, 2, 1 to one set leave way 3 as that set's victim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | An access is reported this cycle |
| acc_set | input | SET_W | Set index of the reported access |
| acc_way | input | 2 | Way used by the reported access |
| vic_set | input | SET_W | Set index of the victim query |
| vic_way | output | 2 | Way to replace in the queried set |

## Verification
The bound checker watches four things on every cycle. After reset the victim is way 3. After an access, the victim of the touched set moves to the other half and away from the touched way. An idle cycle does not disturb the answer to an unchanged query. The victim is also never unknown. Some behaviours need a model of the whole history across many sets, so only the bench scenarios can show them. These are the exact victim after long mixed sequences, the isolation between sets, the pre-update answer for a same-cycle access and query, and the 3, 0, 2, 1 example.

// File: rtl/plru4_pkg.sv
// Shared types and tree arithmetic for the four-way pseudo-LRU unit.
// Assumes exactly four ways: a three-node tree per set.
package plru4_pkg;

    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int NODES  = WAYS - 1;

    typedef logic [WAY_W-1:0] way_t;

    // hi_node: recency inside ways 2/3; lo_node: inside ways 0/1; top: which half
    typedef struct packed {
        logic hi_node;
        logic lo_node;
        logic top;
    } tree_t;

endpackage

// File: rtl/plru4_tree_update.sv
// Computes the tree of one set after an access to a given way.
// Only the nodes on the path to the way change; the sibling half is kept.
module plru4_tree_update
    import plru4_pkg::*;
(
    input  tree_t cur_tree,
    input  way_t  hit_way,
    output tree_t new_tree
);

    // Point the top node and the half's node at the accessed way.
    always_comb begin
        new_tree     = cur_tree;
        new_tree.top = hit_way[1];
        if (hit_way[1]) begin
            new_tree.hi_node = hit_way[0];
        end else begin
            new_tree.lo_node = hit_way[0];
        end
    end

endmodule

// File: rtl/plru4_victim_pick.sv
// Walks one set's tree against the recorded directions to name a victim.
// Purely combinational; assumes the tree encoding of plru4_pkg.
module plru4_victim_pick
    import plru4_pkg::*;
(
    input  tree_t tree,
    output way_t  victim
);

    logic far_half;

    // Enter the half not used last, then the way not used last inside it.
    always_comb begin
        far_half  = ~tree.top;
        victim[1] = far_half;
        victim[0] = far_half ? ~tree.hi_node : ~tree.lo_node;
    end

endmodule

// File: rtl/plru4_state_bank.sv
// Per-set tree storage with one write port and two combinational read ports.
// Assumes NUM_SETS is a power of two so every index addresses a set.
module plru4_state_bank
    import plru4_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  tree_t            wr_tree,
    input  logic [SET_W-1:0] rd_set_upd,
    output tree_t            rd_tree_upd,
    input  logic [SET_W-1:0] rd_set_vic,
    output tree_t            rd_tree_vic
);

    tree_t trees [NUM_SETS];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        // Hold one set's tree: clear on reset, load when this set is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trees[g] <= '0;
            end else if (wr_en && (wr_set == SET_W'(g))) begin
                trees[g] <= wr_tree;
            end
        end
    end

    // Read ports return the registered state, i.e. before this cycle's write.
    always_comb begin
        rd_tree_upd = trees[rd_set_upd];
        rd_tree_vic = trees[rd_set_vic];
    end

endmodule

// File: rtl/plru4_repl_unit.sv
// Four-way tree pseudo-LRU replacement unit, top level.
// Accesses update the named set at the clock edge; victim queries are
// answered combinationally from the state held before that edge.
module plru4_repl_unit
    import plru4_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [1:0]       acc_way,
    input  logic [SET_W-1:0] vic_set,
    output logic [1:0]       vic_way
);

    tree_t cur_acc_tree;
    tree_t nxt_acc_tree;
    tree_t cur_vic_tree;
    way_t  picked;

    plru4_state_bank #(
        .NUM_SETS (NUM_SETS),
        .SET_W    (SET_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (acc_valid),
        .wr_set      (acc_set),
        .wr_tree     (nxt_acc_tree),
        .rd_set_upd  (acc_set),
        .rd_tree_upd (cur_acc_tree),
        .rd_set_vic  (vic_set),
        .rd_tree_vic (cur_vic_tree)
    );

    plru4_tree_update u_upd (
        .cur_tree (cur_acc_tree),
        .hit_way  (acc_way),
        .new_tree (nxt_acc_tree)
    );

    plru4_victim_pick u_pick (
        .tree   (cur_vic_tree),
        .victim (picked)
    );

    // Drive the victim output from the tree walk.
    always_comb begin
        vic_way = picked;
    end

endmodule

// File: rtl/plru4_repl_chk.sv
// Property checker for plru4_repl_unit, attached through bind below.
// Observes only the top-level ports.
module plru4_repl_chk #(
    parameter int SET_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic [1:0]       acc_way,
    input logic [SET_W-1:0] vic_set,
    input logic [1:0]       vic_way
);

    logic rst_seen;

    // Remember that a reset has been applied, so the R1 check has a base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen <= 1'b1;
        end else if (rst_seen !== 1'b1) begin
            rst_seen <= 1'b0;
        end
    end

    p_reset_victim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen === 1'b1 && !$past(rst_n)) |-> (vic_way == 2'd3));

    p_other_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ((vic_set == $past(acc_set)) -> (vic_way[1] != $past(acc_way[1]))));

    p_not_recent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ((vic_set == $past(acc_set)) -> (vic_way != $past(acc_way))));

    p_known_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(vic_way));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ($stable(vic_set) -> $stable(vic_way)));

endmodule

bind plru4_repl_unit plru4_repl_chk #(.SET_W(SET_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .vic_set   (vic_set),
    .vic_way   (vic_way)
);

// File: tb/tb_plru4_repl_unit.sv
// Self-checking bench with a behavioural recency model per set.
module tb_plru4_repl_unit;

    localparam int NUM_SETS = 64;
    localparam int SET_W    = $clog2(NUM_SETS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic [1:0]       acc_way = '0;
    logic [SET_W-1:0] vic_set = '0;
    logic [1:0]       vic_way;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model: which half was used last, and within each half which member.
    int half_last [NUM_SETS];
    int member_last [NUM_SETS][2];

    plru4_repl_unit #(.NUM_SETS(NUM_SETS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .vic_set   (vic_set),
        .vic_way   (vic_way)
    );

    always #5 clk = ~clk;

    function automatic int model_victim(int s);
        int h;
        h = 1 - half_last[s];
        return 2 * h + (1 - member_last[s][h]);
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < NUM_SETS; s++) begin
            half_last[s] = 0;
            member_last[s][0] = 0;
            member_last[s][1] = 0;
        end
    endfunction

    function automatic void model_touch(int s, int w);
        half_last[s] = w / 2;
        member_last[s][w / 2] = w % 2;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: vic_set=%0d victim got %0d expected %0d", tag, vic_set, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(bit v, int s, int w, int q, string tag);
        @(negedge clk);
        acc_valid = v;
        acc_set   = SET_W'(s);
        acc_way   = 2'(w);
        vic_set   = SET_W'(q);
        #1;
        check(tag, int'(vic_way), model_victim(q));
        if (v && rst_n) model_touch(s, w);
        @(posedge clk);
    endtask

    initial begin
        model_clear();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every set starts with victim 3
        for (int s = 0; s < NUM_SETS; s++) begin
            @(negedge clk);
            vic_set = SET_W'(s);
            #1;
            check("R1", int'(vic_way), 3);
        end
        // R8: the sequence 3,0,2,1 leaves way 3 as victim
        step(1, 5, 3, 5, "R8");
        step(1, 5, 0, 5, "R8");
        step(1, 5, 2, 5, "R8");
        step(1, 5, 1, 5, "R8");
        @(negedge clk);
        acc_valid = 1'b0;
        vic_set = SET_W'(5);
        #1;
        check("R8", int'(vic_way), 3);
        // R7: same-cycle access and query see the old state (victim still 3)
        step(1, 5, 3, 5, "R7");
        step(0, 5, 0, 5, "R7");
        // R2/R4: accessing way 0 then way 2 in a fresh set
        step(1, 9, 0, 9, "R4");
        step(0, 0, 0, 9, "R2");
        step(1, 9, 2, 9, "R4");
        step(0, 0, 0, 9, "R2");
        // R3: hit the current victim, then it must move elsewhere
        step(1, 9, model_victim(9), 9, "R3");
        step(0, 0, 0, 9, "R3");
        // R6: set 6 touched, neighbours 7 and 5 unchanged
        step(1, 6, 3, 7, "R6");
        step(0, 0, 0, 7, "R6");
        step(0, 0, 0, 5, "R6");
        // R5: invalid accesses carrying set and way must not change anything
        step(0, 9, 1, 9, "R5");
        step(0, 9, 3, 9, "R5");
        step(0, 9, 0, 9, "R5");
        // R4: long mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, $urandom % 8, $urandom % 4, $urandom % 8, "R4");
        end
        // R1: reset in the middle of traffic clears every set again
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        acc_valid = 1'b0;
        model_clear();
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            vic_set = SET_W'(s);
            #1;
            check("R1", int'(vic_way), 3);
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule